// File: doc/BRIEF.md
# Multistage Shuffle-Exchange Switching Network

This block moves one data word per cycle from each of P source ports to P destination ports through a log2(P)-deep cascade of two-by-two switching elements. Before every column of switches the links are rewired with a perfect shuffle, so each port index is rotated left by one bit. Each element sets itself from the destination address: in stage k it looks at address bit AW-1-k, counted from the most significant bit. The bit selects the element's upper output (0) or lower output (1). Seen from the element, this means the straight setting when the current leading source and destination bits agree and the exchange setting when they differ.

The network is blocking. When both valid inputs of one element need the same output, the element cannot serve both settings. The packet from the lower source index keeps the element, and the other packet is discarded. The source that lost is flagged as blocked for that cycle. There is no queueing and no retry: a blocked source must present its packet again. Results are registered, so delivered words, valid flags and blocked flags appear one clock after the inputs. P must be a power of two.

Top module: `omega_network`

## Requirements
- R1: All outputs are registered. Inputs sampled at a rising edge appear on `out_valid`, `out_data` and `out_blocked` after that edge. An active-high synchronous reset clears every valid and blocked flag.
- R2: For any input pattern with no conflicts, every valid packet arrives in the same cycle at the output port whose index equals its destination address, carrying its data word unchanged.
- R3: Routing follows the destination tag. Links between stages rotate the port index left by one bit. Stage k, numbered from 0 at the inputs, sends a packet to the upper output of its element when destination bit AW-1-k is 0 and to the lower output when that bit is 1.
- R4: When two valid packets in one element need the same element output, the packet from the lower source index proceeds. The other packet is dropped and its source's bit in `out_blocked` is 1 for that one cycle.
- R5: An invalid input never sets a blocked flag and never influences the setting of an element.
- R6: In every cycle, each valid source is counted exactly once: either it is delivered to one output or it is flagged as blocked.
- R7: A cycle with at most one valid source never shows a blocked flag, and that packet reaches its destination.
- R8: Source 0 is never blocked.
- R9: A blocked packet is not held or retried. After a cycle with no valid inputs, all valid and blocked flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | P | Per-source packet present |
| in_dest | input | P*AW | Destination address per source; source i uses bits [i*AW +: AW] |
| in_data | input | P*DW | Data word per source; source i uses bits [i*DW +: DW] |
| out_valid | output | P | Per-destination packet delivered |
| out_data | output | P*DW | Data word per destination; port j uses bits [j*DW +: DW] |
| out_blocked | output | P | Per-source flag: this source's packet was dropped in a conflict |

## Verification
Suppose an element picks the wrong setting, or a shuffle link is miswired. A packet would then land on a neighbouring output port, or its data word would be exchanged with another packet's word. This shows on `out_valid` or `out_data` one cycle after the pattern is applied. A fault in the priority or drop logic shows in the same cycle on `out_blocked`: either the wrong source is flagged, or a source is both delivered and flagged. Since no state survives past one cycle, every fault is visible within one clock of the pattern that exposes it.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic {
        SW_STRAIGHT = 1'b0,
        SW_EXCHANGE = 1'b1
    } sw_mode_e;

    // Perfect-shuffle link: rotate a width-bit port index left by one
    function automatic int shuffle_idx(input int idx, input int width);
        int top;
        top = (idx >> (width - 1)) & 1;
        return ((idx << 1) | top) & ((1 << width) - 1);
    endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int AW  = 3,
    parameter int DW  = 8,
    parameter int BIT = 2
) (
    input  logic          up_v,
    input  logic          lo_v,
    input  logic [AW-1:0] up_dst,
    input  logic [AW-1:0] lo_dst,
    input  logic [AW-1:0] up_src,
    input  logic [AW-1:0] lo_src,
    input  logic [DW-1:0] up_dat,
    input  logic [DW-1:0] lo_dat,
    output logic          q0_v,
    output logic          q1_v,
    output logic [AW-1:0] q0_dst,
    output logic [AW-1:0] q1_dst,
    output logic [AW-1:0] q0_src,
    output logic [AW-1:0] q1_src,
    output logic [DW-1:0] q0_dat,
    output logic [DW-1:0] q1_dat,
    output logic          up_drop,
    output logic          lo_drop
);

    sw_mode_e up_need, lo_need, mode;
    logic     up_keep, lo_keep;

    always_comb begin
        // upper input reaches output 0 straight; lower input reaches output 1 straight
        up_need = up_dst[BIT] ? SW_EXCHANGE : SW_STRAIGHT;
        lo_need = lo_dst[BIT] ? SW_STRAIGHT : SW_EXCHANGE;
        up_drop = 1'b0;
        lo_drop = 1'b0;
        mode    = SW_STRAIGHT;
        if (up_v && lo_v) begin
            if (up_src < lo_src) begin
                mode    = up_need;
                lo_drop = (lo_need != up_need);
            end else begin
                mode    = lo_need;
                up_drop = (up_need != lo_need);
            end
        end else if (up_v) begin
            mode = up_need;
        end else if (lo_v) begin
            mode = lo_need;
        end
        up_keep = up_v && !up_drop;
        lo_keep = lo_v && !lo_drop;
    end

    always_comb begin
        unique case (mode)
            SW_STRAIGHT: begin
                q0_v = up_keep; q0_dst = up_dst; q0_src = up_src; q0_dat = up_dat;
                q1_v = lo_keep; q1_dst = lo_dst; q1_src = lo_src; q1_dat = lo_dat;
            end
            SW_EXCHANGE: begin
                q0_v = lo_keep; q0_dst = lo_dst; q0_src = lo_src; q0_dat = lo_dat;
                q1_v = up_keep; q1_dst = up_dst; q1_src = up_src; q1_dat = up_dat;
            end
            default: begin
                q0_v = 1'b0; q0_dst = '0; q0_src = '0; q0_dat = '0;
                q1_v = 1'b0; q1_dst = '0; q1_src = '0; q1_dat = '0;
            end
        endcase
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int P   = 8,
    parameter int AW  = 3,
    parameter int DW  = 8,
    parameter int STG = 0
) (
    input  logic [P-1:0]    in_v,
    input  logic [P*AW-1:0] in_dst,
    input  logic [P*AW-1:0] in_src,
    input  logic [P*DW-1:0] in_dat,
    output logic [P-1:0]    out_v,
    output logic [P*AW-1:0] out_dst,
    output logic [P*AW-1:0] out_src,
    output logic [P*DW-1:0] out_dat,
    output logic [P-1:0]    blk
);

    localparam int NSW = P / 2;
    localparam int BIT = AW - 1 - STG;

    logic [P-1:0]    sh_v;
    logic [P*AW-1:0] sh_dst;
    logic [P*AW-1:0] sh_src;
    logic [P*DW-1:0] sh_dat;
    logic [NSW-1:0]  drop_up, drop_lo;

    for (genvar p = 0; p < P; p++) begin : g_link
        localparam int Q = shuffle_idx(p, AW);
        assign sh_v[Q]               = in_v[p];
        assign sh_dst[Q*AW +: AW]    = in_dst[p*AW +: AW];
        assign sh_src[Q*AW +: AW]    = in_src[p*AW +: AW];
        assign sh_dat[Q*DW +: DW]    = in_dat[p*DW +: DW];
    end

    for (genvar j = 0; j < NSW; j++) begin : g_sw
        omega_switch #(.AW(AW), .DW(DW), .BIT(BIT)) u_sw (
            .up_v   (sh_v[2*j]),
            .lo_v   (sh_v[2*j+1]),
            .up_dst (sh_dst[(2*j)*AW +: AW]),
            .lo_dst (sh_dst[(2*j+1)*AW +: AW]),
            .up_src (sh_src[(2*j)*AW +: AW]),
            .lo_src (sh_src[(2*j+1)*AW +: AW]),
            .up_dat (sh_dat[(2*j)*DW +: DW]),
            .lo_dat (sh_dat[(2*j+1)*DW +: DW]),
            .q0_v   (out_v[2*j]),
            .q1_v   (out_v[2*j+1]),
            .q0_dst (out_dst[(2*j)*AW +: AW]),
            .q1_dst (out_dst[(2*j+1)*AW +: AW]),
            .q0_src (out_src[(2*j)*AW +: AW]),
            .q1_src (out_src[(2*j+1)*AW +: AW]),
            .q0_dat (out_dat[(2*j)*DW +: DW]),
            .q1_dat (out_dat[(2*j+1)*DW +: DW]),
            .up_drop(drop_up[j]),
            .lo_drop(drop_lo[j])
        );
    end

    always_comb begin
        blk = '0;
        for (int j = 0; j < NSW; j++) begin
            if (drop_up[j]) blk[sh_src[(2*j)*AW +: AW]]   = 1'b1;
            if (drop_lo[j]) blk[sh_src[(2*j+1)*AW +: AW]] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_network.sv
module omega_network #(
    parameter int P  = 8,
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [P-1:0]             in_valid,
    input  logic [P*$clog2(P)-1:0]   in_dest,
    input  logic [P*DW-1:0]          in_data,
    output logic [P-1:0]             out_valid,
    output logic [P*DW-1:0]          out_data,
    output logic [P-1:0]             out_blocked
);

    localparam int AW = $clog2(P);
    localparam int NS = AW;

    logic [P-1:0]    ch_v   [NS+1];
    logic [P*AW-1:0] ch_dst [NS+1];
    logic [P*AW-1:0] ch_src [NS+1];
    logic [P*DW-1:0] ch_dat [NS+1];
    logic [P-1:0]    st_blk [NS];
    logic [P-1:0]    blk_any;
    logic [P-1:0]    arrived;

    assign ch_v[0]   = in_valid;
    assign ch_dst[0] = in_dest;
    assign ch_dat[0] = in_data;

    for (genvar i = 0; i < P; i++) begin : g_srcid
        assign ch_src[0][i*AW +: AW] = AW'(i);
    end

    for (genvar k = 0; k < NS; k++) begin : g_stage
        omega_stage #(.P(P), .AW(AW), .DW(DW), .STG(k)) u_stage (
            .in_v   (ch_v[k]),
            .in_dst (ch_dst[k]),
            .in_src (ch_src[k]),
            .in_dat (ch_dat[k]),
            .out_v  (ch_v[k+1]),
            .out_dst(ch_dst[k+1]),
            .out_src(ch_src[k+1]),
            .out_dat(ch_dat[k+1]),
            .blk    (st_blk[k])
        );
    end

    always_comb begin
        blk_any = '0;
        for (int k = 0; k < NS; k++) blk_any = blk_any | st_blk[k];
        for (int p = 0; p < P; p++) begin
            arrived[p] = ch_v[NS][p] && (ch_dst[NS][p*AW +: AW] == AW'(p))
                         && (ch_src[NS][p*AW +: AW] <= AW'(P-1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= '0;
            out_blocked <= '0;
        end else begin
            out_valid   <= arrived;
            out_blocked <= blk_any;
        end
    end

    always_ff @(posedge clk) begin
        out_data <= ch_dat[NS];
    end

endmodule

// File: rtl/omega_network_checker.sv
module omega_network_checker #(
    parameter int P = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [P-1:0] in_valid,
    input logic [P-1:0] out_valid,
    input logic [P-1:0] out_blocked
);

    AST_INVALID_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((out_blocked & ~$past(in_valid)) == '0)); // R5

    AST_EACH_SOURCE_ONCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(out_valid) + $countones(out_blocked) == $countones($past(in_valid)))); // R6

    AST_LONE_PACKET_FREE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_valid) |=> (out_blocked == '0)); // R7

    AST_SOURCE0_WINS: assert property (@(posedge clk) disable iff (rst)
        in_valid[0] |=> !out_blocked[0]); // R8

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (in_valid == '0) |=> (out_valid == '0 && out_blocked == '0)); // R9

endmodule

bind omega_network omega_network_checker #(.P(P)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_blocked(out_blocked)
);

// File: tb/omega_network_tb.sv
module omega_network_tb;

    localparam int P  = 8;
    localparam int AW = 3;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [P-1:0]      in_valid = '0;
    logic [P*AW-1:0]   in_dest  = '0;
    logic [P*DW-1:0]   in_data  = '0;
    logic [P-1:0]      out_valid;
    logic [P*DW-1:0]   out_data;
    logic [P-1:0]      out_blocked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int mv[P]; int md[P]; int ms[P]; int mx[P];
    logic [P-1:0]    ev, eb;
    logic [P*DW-1:0] ex;

    always #2.5 clk = ~clk;

    omega_network #(.P(P), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .out_blocked(out_blocked)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Destination-tag walk: rotate positions, then steer by address bit MSB first
    task automatic model();
        int tv[P]; int td[P]; int ts[P]; int tx[P];
        eb = '0;
        for (int k = 0; k < AW; k++) begin
            for (int p = 0; p < P; p++) begin
                int q;
                q = ((p << 1) | (p >> (AW - 1))) & (P - 1);
                tv[q] = mv[p]; td[q] = md[p]; ts[q] = ms[p]; tx[q] = mx[p];
            end
            for (int p = 0; p < P; p++) mv[p] = 0;
            for (int j = 0; j < P / 2; j++) begin
                int a; int b; int wa; int wb;
                a = 2 * j; b = 2 * j + 1;
                wa = (td[a] >> (AW - 1 - k)) & 1;
                wb = (td[b] >> (AW - 1 - k)) & 1;
                if (tv[a] != 0 && tv[b] != 0 && wa == wb) begin
                    if (ts[a] < ts[b]) begin eb[ts[b]] = 1'b1; tv[b] = 0; end
                    else               begin eb[ts[a]] = 1'b1; tv[a] = 0; end
                end
                if (tv[a] != 0) begin
                    mv[2*j+wa] = 1; md[2*j+wa] = td[a]; ms[2*j+wa] = ts[a]; mx[2*j+wa] = tx[a];
                end
                if (tv[b] != 0) begin
                    mv[2*j+wb] = 1; md[2*j+wb] = td[b]; ms[2*j+wb] = ts[b]; mx[2*j+wb] = tx[b];
                end
            end
        end
        ev = '0; ex = '0;
        for (int p = 0; p < P; p++) if (mv[p] != 0) begin
            ev[p] = 1'b1;
            ex[p*DW +: DW] = DW'(mx[p]);
        end
    endtask

    task automatic apply(input logic [P-1:0] v, input logic [P*AW-1:0] d,
                         input logic [P*DW-1:0] x, input string req);
        logic [P*DW-1:0] mask;
        @(negedge clk);
        in_valid = v; in_dest = d; in_data = x;
        for (int i = 0; i < P; i++) begin
            mv[i] = int'(v[i]); md[i] = int'(d[i*AW +: AW]); ms[i] = i; mx[i] = int'(x[i*DW +: DW]);
        end
        model();
        @(posedge clk);
        @(negedge clk);
        mask = '0;
        for (int p = 0; p < P; p++) if (ev[p]) mask[p*DW +: DW] = '1;
        check(out_valid == ev, {req, " valid"}, 64'(out_valid), 64'(ev));
        check((out_data & mask) == ex, {req, " data"}, 64'(out_data & mask), 64'(ex));
        check(out_blocked == eb, {req, " blocked"}, 64'(out_blocked), 64'(eb));
    endtask

    initial begin
        logic [P*AW-1:0] d;
        logic [P*DW-1:0] x;
        // R1: reset clears outputs even with valid inputs present
        in_valid = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == '0, "R1 reset valid", 64'(out_valid), 64'h0);
        check(out_blocked == '0, "R1 reset blocked", 64'(out_blocked), 64'h0);
        rst = 1'b0;
        in_valid = '0;

        // R2: identity and cyclic shifts are conflict-free permutations
        for (int sft = 0; sft < P; sft++) begin
            for (int i = 0; i < P; i++) begin
                d[i*AW +: AW] = AW'((i + sft) % P);
                x[i*DW +: DW] = DW'(8'h40 + i * 3 + sft);
            end
            apply('1, d, x, "R2");
            check(out_blocked == '0 && out_valid == '1, "R2 no conflict", 64'(out_blocked), 64'h0);
        end

        // R7 R3: every lone source to every destination
        for (int s = 0; s < P; s++) begin
            for (int t = 0; t < P; t++) begin
                d = '0; x = '0;
                d[s*AW +: AW] = AW'(t);
                x[s*DW +: DW] = DW'(s * 16 + t);
                apply(P'(1) << s, d, x, "R7/R3 single");
                check(out_valid == (P'(1) << t), "R3 lone arrival", 64'(out_valid), 64'(P'(1) << t));
            end
        end

        // R4: sources 0 and 4 share the first element and both want port 0
        d = '0; x = '0;
        x[0 +: DW] = 8'hA0; x[4*DW +: DW] = 8'hA4;
        apply(8'h11, d, x, "R4 conflict");
        check(out_blocked == 8'h10, "R4 loser flagged", 64'(out_blocked), 64'h10);
        check(out_valid == 8'h01 && out_data[0 +: DW] == 8'hA0, "R4 winner data",
              64'(out_data[0 +: DW]), 64'hA0);

        // R9: an idle cycle afterwards shows nothing held over
        apply('0, '0, '0, "R9 idle");
        check(out_valid == '0 && out_blocked == '0, "R9 cleared", 64'(out_blocked), 64'h0);

        // R5: invalid sources ignored; only source 6 active while others aim at same port
        d = '0; x = '1;
        apply(8'h40, d, x, "R5 invalid ignored");
        check(out_valid == 8'h01 && out_blocked == '0, "R5 lone among idle", 64'(out_valid), 64'h01);

        // R4 R5 R6 R8: random masks and destinations
        for (int r = 0; r < 600; r++) begin
            logic [P-1:0] v;
            v = P'($urandom());
            d = (P*AW)'({$urandom(), $urandom()});
            x = (P*DW)'({$urandom(), $urandom()});
            apply(v, d, x, "R4/R5/R6 random");
            check(!(v[0] && out_blocked[0]), "R8 source0", 64'(out_blocked), 64'h0);
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule